// File: doc/BRIEF.md
# Shared Receive Packet FIFO

This block is the one receive buffer that every OUT endpoint of a USB device-mode core writes into. The packet-receive logic opens a packet with a start beat that carries the endpoint number. It then pushes payload bytes one at a time and closes the packet with an end beat that carries the data PID and the CRC verdict. The end beat writes a status word into the same storage, directly after the packet's bytes. A drain port, standing in for a DMA reader, pops words in arrival order with a show-ahead interface. The drain port can run while a later packet is still being received.

A packet is committed as a unit. Its bytes occupy storage from the moment they arrive, but the reader's occupancy count only grows when the status word is written. If a byte would leave no slot for the status word, the packet is abandoned and the write pointer falls back to the last committed position. When that packet's end beat arrives, the block pulses a NAK request to the protocol layer. A packet that fails its CRC is still committed, with its valid flag cleared, so software can count the error.

Top module: `rx_pkt_fifo`

## Requirements
- R1: Reset empties the buffer. After reset, `rd_level` is 0, `rd_valid` is 0 and `nak` is 0.
- R2: Each stored word has a tag (`rd_is_status`) and an 18-bit body.
  - A data word has tag 0, the payload byte in body[7:0] and zeros above it.
  - A status word has tag 1 and carries the endpoint in [3:0], the byte count in [14:4], the PID in [16:15] and the valid flag in [17]. The PID codes are 00 DATA0, 01 DATA1, 10 DATA2 and 11 MDATA, passed through unchanged.
- R3: Start beats and byte beats never change `rd_level`. In the cycle after an accepted end beat, `rd_level` has grown by the packet's byte count plus one.
- R4: Words leave in arrival order: a packet's bytes in order, then its status word. Packets from different endpoints share one stream.
- R5: A pop while `rd_valid` is high removes the head word by the next cycle. This also works while another packet is being received. A pop while `rd_valid` is low changes nothing.
- R6: A byte is accepted only if, counting uncommitted words, at least two slots stay free. The first refused byte drops the whole packet: its bytes are discarded and no status word is written. `nak` is high for exactly the one cycle after that packet's end beat.
- R7: An end beat with `pkt_crc_ok` low still commits the packet, with status bit [17] equal to 0.
- R8: A start beat while a packet is open discards that packet's bytes without a status word and without `nak`.
- R9: Byte beats and end beats that arrive with no open packet are ignored. They change neither `rd_level` nor `nak`.
- R10: `rd_level` never exceeds DEPTH. A packet of DEPTH-1 bytes fills an empty buffer exactly. The space freed by a dropped packet is reused by the next one.
- R11: A packet with no bytes commits a single status word with byte count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Opens a packet, one-cycle beat |
| pkt_ep | input | 4 | Endpoint number, sampled with `pkt_start` |
| pkt_byte_vld | input | 1 | Payload byte beat |
| pkt_byte | input | 8 | Payload byte |
| pkt_end | input | 1 | Closes the open packet |
| pkt_pid | input | 2 | Data PID, sampled with `pkt_end` |
| pkt_crc_ok | input | 1 | CRC verdict, sampled with `pkt_end` |
| nak | output | 1 | One-cycle request to answer NAK |
| rd_pop | input | 1 | Removes the head word |
| rd_valid | output | 1 | At least one committed word is waiting |
| rd_is_status | output | 1 | Head word is a status word |
| rd_word | output | 18 | Head word body |
| rd_level | output | clog2(DEPTH)+1 | Committed words waiting |

## Verification
A write pointer that fails to roll back shows up one packet later. The next committed packet reports a level that is too large, and its bytes are shifted behind stale data, so the first drained word differs from the expected byte. A committed pointer that moves early shows in `rd_level` on the very cycle after a byte beat, before any end beat. A wrong free-space limit shows as a packet of DEPTH-1 bytes being refused, or as a DEPTH-byte packet being accepted. In either case it becomes visible on `nak` and `rd_level` in the cycle after the end beat.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int EP_W   = 4;
    localparam int BCNT_W = 11;
    localparam int PID_W  = 2;
    localparam int BODY_W = 18;

    typedef enum logic [PID_W-1:0] {
        PID_DATA0 = 2'b00,
        PID_DATA1 = 2'b01,
        PID_DATA2 = 2'b10,
        PID_MDATA = 2'b11
    } pid_e;

    typedef struct packed {
        logic              ok;
        pid_e              pid;
        logic [BCNT_W-1:0] bcnt;
        logic [EP_W-1:0]   ep;
    } sts_t;

    typedef struct packed {
        logic              is_sts;
        logic [BODY_W-1:0] body;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    function automatic entry_t mk_data(input logic [7:0] b);
        entry_t e;
        e.is_sts = 1'b0;
        e.body   = {{(BODY_W-8){1'b0}}, b};
        return e;
    endfunction

    function automatic entry_t mk_sts(input sts_t s);
        entry_t e;
        e.is_sts = 1'b1;
        e.body   = s;
        return e;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [AW-1:0] raddr,
    output entry_t        rdata
);

    entry_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pkt_start,
    input  logic [EP_W-1:0] pkt_ep,
    input  logic            pkt_byte_vld,
    input  logic [7:0]      pkt_byte,
    input  logic            pkt_end,
    input  logic [PID_W-1:0] pkt_pid,
    input  logic            pkt_crc_ok,
    input  logic [PW-1:0]   rd_ptr,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output entry_t          wdata,
    output logic [PW-1:0]   commit_ptr,
    output logic            nak
);

    localparam logic [PW-1:0] BYTE_LIM = PW'(DEPTH - 2);
    localparam logic [PW-1:0] STS_LIM  = PW'(DEPTH - 1);
    localparam logic [PW-1:0] ONE      = PW'(1);

    logic              open_q;
    logic              drop_q;
    logic [PW-1:0]     wp_q;
    logic [PW-1:0]     cp_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [EP_W-1:0]   ep_q;
    logic              nak_q;

    logic [PW-1:0] used;
    logic          room_byte;
    logic          room_sts;
    logic          live;
    sts_t          sts;

    always_comb begin
        used      = wp_q - rd_ptr;
        room_byte = (used <= BYTE_LIM);
        room_sts  = (used <= STS_LIM);
        live      = open_q && !drop_q;
        sts.ok    = pkt_crc_ok;
        sts.pid   = pid_e'(pkt_pid);
        sts.bcnt  = bcnt_q;
        sts.ep    = ep_q;
    end

    always_comb begin
        we    = 1'b0;
        wdata = mk_data(pkt_byte);
        if (pkt_start) begin
            we = 1'b0;
        end else if (pkt_end) begin
            if (live && room_sts) begin
                we    = 1'b1;
                wdata = mk_sts(sts);
            end
        end else if (pkt_byte_vld && live && room_byte) begin
            we = 1'b1;
        end
    end

    assign waddr = wp_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            drop_q <= 1'b0;
            wp_q   <= '0;
            cp_q   <= '0;
            bcnt_q <= '0;
            ep_q   <= '0;
            nak_q  <= 1'b0;
        end else begin
            nak_q <= 1'b0;
            if (pkt_start) begin
                open_q <= 1'b1;
                drop_q <= 1'b0;
                wp_q   <= cp_q;
                bcnt_q <= '0;
                ep_q   <= pkt_ep;
            end else if (pkt_end) begin
                if (open_q) begin
                    open_q <= 1'b0;
                    drop_q <= 1'b0;
                    if (!drop_q && room_sts) begin
                        wp_q <= wp_q + ONE;
                        cp_q <= wp_q + ONE;
                    end else begin
                        wp_q  <= cp_q;
                        nak_q <= 1'b1;
                    end
                end
            end else if (pkt_byte_vld && live) begin
                if (room_byte) begin
                    wp_q   <= wp_q + ONE;
                    bcnt_q <= bcnt_q + 1'b1;
                end else begin
                    drop_q <= 1'b1;
                    wp_q   <= cp_q;
                end
            end
        end
    end

    assign commit_ptr = cp_q;
    assign nak        = nak_q;

endmodule

// File: rtl/rxf_rd_ctl.sv
module rxf_rd_ctl #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_pop,
    input  logic [PW-1:0] commit_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [AW-1:0] raddr,
    output logic          rd_valid,
    output logic [PW-1:0] rd_level
);

    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] rp_q;

    always_comb begin
        rd_level = commit_ptr - rp_q;
        rd_valid = (rd_level != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q <= '0;
        end else if (rd_pop && rd_valid) begin
            rp_q <= rp_q + ONE;
        end
    end

    assign rd_ptr = rp_q;
    assign raddr  = rp_q[AW-1:0];

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_start,
    input  logic [EP_W-1:0]    pkt_ep,
    input  logic               pkt_byte_vld,
    input  logic [7:0]         pkt_byte,
    input  logic               pkt_end,
    input  logic [PID_W-1:0]   pkt_pid,
    input  logic               pkt_crc_ok,
    output logic               nak,
    input  logic               rd_pop,
    output logic               rd_valid,
    output logic               rd_is_status,
    output logic [BODY_W-1:0]  rd_word,
    output logic [PW-1:0]      rd_level
);

    logic          we;
    logic [AW-1:0] waddr;
    entry_t        wdata;
    logic [AW-1:0] raddr;
    entry_t        rdata;
    logic [PW-1:0] commit_ptr;
    logic [PW-1:0] rd_ptr;

    rxf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk          (clk),
        .rst          (rst),
        .pkt_start    (pkt_start),
        .pkt_ep       (pkt_ep),
        .pkt_byte_vld (pkt_byte_vld),
        .pkt_byte     (pkt_byte),
        .pkt_end      (pkt_end),
        .pkt_pid      (pkt_pid),
        .pkt_crc_ok   (pkt_crc_ok),
        .rd_ptr       (rd_ptr),
        .we           (we),
        .waddr        (waddr),
        .wdata        (wdata),
        .commit_ptr   (commit_ptr),
        .nak          (nak)
    );

    rxf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_pop     (rd_pop),
        .commit_ptr (commit_ptr),
        .rd_ptr     (rd_ptr),
        .raddr      (raddr),
        .rd_valid   (rd_valid),
        .rd_level   (rd_level)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign rd_is_status = rdata.is_sts;
    assign rd_word      = rdata.body;

endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               pkt_start,
    input logic               pkt_byte_vld,
    input logic               pkt_end,
    input logic               nak,
    input logic               rd_pop,
    input logic               rd_valid,
    input logic [PW-1:0]      rd_level
);

    localparam logic [PW-1:0] LVL_MAX = PW'(DEPTH);
    localparam logic [PW-1:0] ONE     = PW'(1);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (rd_level == '0 && !nak && !rd_valid)); // R1

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        rd_level <= LVL_MAX); // R10

    AST_NAK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        nak |=> !nak); // R6

    AST_NAK_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> (!nak || rd_level <= $past(rd_level))); // R6

    AST_HIDDEN_UNTIL_END: assert property (@(posedge clk) disable iff (rst)
        (!pkt_end && !rd_pop) |=> $stable(rd_level)); // R3

    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && rd_valid && !pkt_end) |=> (rd_level == $past(rd_level) - ONE)); // R5

    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !rd_valid && !pkt_end) |=> (rd_level == '0)); // R5

    AST_START_NO_NAK: assert property (@(posedge clk) disable iff (rst)
        (pkt_start || pkt_byte_vld) |=> !nak); // R8

endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_pkt_fifo_test.sv
module rx_pkt_fifo_test;

    localparam int DEPTH = 16;
    localparam int PW = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_start = 1'b0;
    logic [3:0] pkt_ep = '0;
    logic pkt_byte_vld = 1'b0;
    logic [7:0] pkt_byte = '0;
    logic pkt_end = 1'b0;
    logic [1:0] pkt_pid = '0;
    logic pkt_crc_ok = 1'b0;
    logic rd_pop = 1'b0;
    logic nak;
    logic rd_valid;
    logic rd_is_status;
    logic [17:0] rd_word;
    logic [PW-1:0] rd_level;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2ns clk = ~clk;

    rx_pkt_fifo #(.DEPTH(DEPTH)) uut (.*);

    // vector table: endpoint, byte count, pid, crc ok
    localparam int NV = 6;
    localparam int VEC [NV][4] = '{
        '{3, 4, 1, 1},
        '{0, 0, 0, 1},
        '{9, 7, 2, 0},
        '{15, 15, 3, 1},
        '{5, 1, 0, 0},
        '{12, 2, 1, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic e, input logic v, input logic [7:0] b,
                         input logic [3:0] ep, input logic [1:0] pid, input logic ok,
                         input logic rd);
        @(negedge clk);
        pkt_start = s; pkt_end = e; pkt_byte_vld = v; pkt_byte = b;
        pkt_ep = ep; pkt_pid = pid; pkt_crc_ok = ok; rd_pop = rd;
        @(posedge clk);
        #1ns;
        pkt_start = 0; pkt_end = 0; pkt_byte_vld = 0; pkt_byte = '0;
        pkt_ep = '0; pkt_pid = '0; pkt_crc_ok = 0; rd_pop = 0;
    endtask

    task automatic t_start(input int ep);
        drive(1, 0, 0, 8'h00, 4'(ep), 2'b00, 0, 0);
    endtask
    task automatic t_byte(input int b, input logic rd);
        drive(0, 0, 1, 8'(b), 4'h0, 2'b00, 0, rd);
    endtask
    task automatic t_end(input int pid, input logic ok);
        drive(0, 1, 0, 8'h00, 4'h0, 2'(pid), ok, 0);
    endtask
    task automatic t_pop();
        drive(0, 0, 0, 8'h00, 4'h0, 2'b00, 0, 1);
    endtask
    task automatic t_idle();
        drive(0, 0, 0, 8'h00, 4'h0, 2'b00, 0, 0);
    endtask

    function automatic int sts_word(input int ep, input int n, input int pid, input int ok);
        return (ok << 17) | (pid << 15) | (n << 4) | ep;
    endfunction

    task automatic send_pkt(input int ep, input int n, input int pid, input int ok, input int base);
        int lvl0;
        lvl0 = int'(rd_level);
        t_start(ep);
        for (int i = 0; i < n; i++) t_byte(base + i, 0);
        chk("R3 level hidden before end", int'(rd_level), lvl0);
        t_end(pid, ok != 0);
    endtask

    task automatic drain_pkt(input int ep, input int n, input int pid, input int ok, input int base);
        for (int i = 0; i < n; i++) begin
            chk("R2 data tag", int'(rd_is_status), 0);
            chk("R4 data byte order", int'(rd_word), (base + i) & 255);
            t_pop();
        end
        chk("R2 status tag", int'(rd_is_status), 1);
        chk("R2 status word", int'(rd_word), sts_word(ep, n, pid, ok));
        t_pop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1ns rst = 0;
        @(negedge clk);
        chk("R1 reset level", int'(rd_level), 0);
        chk("R1 reset valid", int'(rd_valid), 0);
        chk("R1 reset nak", int'(nak), 0);

        // table walk: R2 R3 R4 R7 R10 R11
        for (int k = 0; k < NV; k++) begin
            int base;
            base = 16 * k + 1;
            send_pkt(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], base);
            chk("R3 level after end", int'(rd_level), VEC[k][1] + 1);
            chk("R7 nak low on commit", int'(nak), 0);
            drain_pkt(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], base);
            chk("R10 drained", int'(rd_level), 0);
        end

        // R5: drain while the next packet is arriving
        send_pkt(2, 2, 1, 1, 8'hA0);
        chk("R3 level A", int'(rd_level), 3);
        t_start(6);
        chk("R5 head A0", int'(rd_word), 'hA0);
        t_byte('hB0, 1);
        chk("R5 head A1", int'(rd_word), 'hA1);
        chk("R5 level pop 1", int'(rd_level), 2);
        t_byte('hB1, 1);
        chk("R5 head status A", int'(rd_word), sts_word(2, 2, 1, 1));
        t_byte('hB2, 1);
        chk("R5 level drained mid packet", int'(rd_level), 0);
        t_end(0, 1);
        chk("R4 level B", int'(rd_level), 4);
        drain_pkt(6, 3, 0, 1, 'hB0);

        // R5: pop on empty is ignored
        t_pop();
        chk("R5 empty pop level", int'(rd_level), 0);
        chk("R5 empty pop valid", int'(rd_valid), 0);

        // R6: DEPTH bytes into an empty buffer overflows
        send_pkt(1, 16, 1, 1, 'h40);
        chk("R6 nak after overflow", int'(nak), 1);
        chk("R6 nothing committed", int'(rd_level), 0);
        t_idle();
        chk("R6 nak one cycle", int'(nak), 0);
        send_pkt(4, 3, 2, 1, 'h70);
        chk("R10 space reused", int'(rd_level), 4);
        drain_pkt(4, 3, 2, 1, 'h70);

        // R6: overflow with committed data present
        send_pkt(7, 10, 0, 1, 'h10);
        chk("R3 level 10 byte packet", int'(rd_level), 11);
        send_pkt(8, 5, 1, 1, 'h80);
        chk("R6 nak partial", int'(nak), 1);
        chk("R6 level kept", int'(rd_level), 11);
        drain_pkt(7, 10, 0, 1, 'h10);
        send_pkt(8, 5, 1, 1, 'h80);
        chk("R10 retry fits", int'(rd_level), 6);
        drain_pkt(8, 5, 1, 1, 'h80);

        // R8: restart discards the open packet
        t_start(3);
        t_byte('h55, 0);
        t_byte('h56, 0);
        t_byte('h57, 0);
        t_start(10);
        chk("R8 no nak on restart", int'(nak), 0);
        t_byte('hC0, 0);
        t_byte('hC1, 0);
        t_end(3, 1);
        chk("R8 only new packet", int'(rd_level), 3);
        chk("R8 no nak", int'(nak), 0);
        drain_pkt(10, 2, 3, 1, 'hC0);

        // R9: beats with no open packet
        t_byte('h99, 0);
        t_end(1, 1);
        chk("R9 stray end level", int'(rd_level), 0);
        chk("R9 stray end nak", int'(nak), 0);
        t_idle();
        chk("R9 still empty", int'(rd_valid), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule